// File: doc/BRIEF.md
# LPC Target SYNC Wait-State Generator

This block owns the SYNC phase of a Low Pin Count target. A cycle decoder tells it, with a one-clock `cyc_start` pulse, that the current bus cycle addresses this device. The pulse comes with the cycle class, the direction and the byte count. After a fixed lead-in the block takes the 4-bit LAD bus. It drives wait nibbles until the local function raises `fn_ready` or `fn_error`, and then drives the matching completion nibble.

On reads, the block then passes two data nibbles from the serial data shifter (`rd_nib`) onto the bus. It repeats the SYNC and data steps for each byte of a multi-byte read. At the end it releases the bus for one turnaround clock and returns to idle.

The wait nibble is selected once, from the cycle class captured at the start pulse, and is used for every wait state of that cycle. An error completion still lets the data nibbles of the current read byte go out, but it stops any later bytes.

Top module: `lpc_sync_gen`

## Requirements
- R1: While reset is held and right after it, `lad_oe` and `cyc_done` are 0.
- R2: With `cyc_start` sampled high at clock edge E while idle, the first SYNC nibble is on `lad_out` with `lad_oe` high after edge E+SYNC_DELAY-1 (SYNC_DELAY from 1 to 3, default 2). `lad_oe` stays low before that.
- R3: A wait nibble is driven while in SYNC with neither `fn_ready` nor `fn_error` high. It is 4'b0101 when `cyc_type` was 2'b10 (DMA) at the start pulse. It is 4'b0110 for 2'b00 (I/O) and for 2'b01 (memory, default configuration). The choice holds for the whole cycle even if `cyc_type` changes later.
- R4: The ready completion nibble is 4'b0000. It is 4'b1001 when the cycle is DMA and `dma_more` is high.
- R5: The error completion nibble is 4'b1010. When `fn_ready` and `fn_error` are high in the same clock, the error nibble is driven.
- R6: On a read, the two clocks after each completion nibble carry `rd_nib` on `lad_out` with `lad_oe` high. `data_phase` is high for both clocks. `data_nib_hi` is 0 in the first clock and 1 in the second.
- R7: A read carries `cyc_nbytes`+1 bytes, and each byte has its own SYNC phase. An error completion ends the cycle after that byte's two data nibbles, so no further SYNC follows.
- R8: A write ends after a single completion nibble, with no data phase, whatever `cyc_nbytes` is.
- R9: After the last SYNC or data clock, `cyc_done` is high and `lad_oe` is low for exactly one clock. The block is then idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock pulse: decoded cycle addresses this device |
| cyc_type | input | 2 | Cycle class: 00 I/O, 01 memory, 10 DMA |
| cyc_rd | input | 1 | 1 when the target returns data |
| cyc_nbytes | input | BCW | Byte count minus one |
| fn_ready | input | 1 | Local function has completed the byte |
| fn_error | input | 1 | Local function reports a failure |
| dma_more | input | 1 | Function requests further DMA transfers |
| rd_nib | input | 4 | Read data nibble from the shifter |
| lad_out | output | 4 | Value driven onto LAD |
| lad_oe | output | 1 | LAD output enable |
| data_phase | output | 1 | Read data nibble slot active |
| data_nib_hi | output | 1 | 0 for the low nibble slot, 1 for the high |
| cyc_done | output | 1 | Turnaround clock of an ending cycle |

## Verification
A wrong cycle class latch shows up on the bus as a wrong wait nibble in the first wait clock, which is two clocks after the start pulse by default. A changed `cyc_type` afterwards exposes a class that was not latched. A miscounted byte counter or a lost error flag leaves `lad_oe` high, or produces an extra SYNC, in the clock where turnaround was due. A wrong lead-in count shifts the first driven nibble by whole clocks. The sweep samples every clock of every cycle, so each of these faults is seen in the clock in which it occurs.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_LEAD, ST_SYNC, ST_DAT0, ST_DAT1, ST_TAR
   } sync_st_e;

   localparam logic [1:0] CT_IO  = 2'b00;
   localparam logic [1:0] CT_MEM = 2'b01;
   localparam logic [1:0] CT_DMA = 2'b10;

   localparam logic [3:0] NIB_SHORT = 4'b0101;
   localparam logic [3:0] NIB_LONG  = 4'b0110;
   localparam logic [3:0] NIB_RDY   = 4'b0000;
   localparam logic [3:0] NIB_MORE  = 4'b1001;
   localparam logic [3:0] NIB_ERR   = 4'b1010;
endpackage

// File: rtl/lpc_sync_lead.sv
module lpc_sync_lead #(
   parameter int SYNC_DELAY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic counting,
   output logic lead_done
);
   generate
      if (SYNC_DELAY == 1) begin : g_direct
         logic unused_lead;
         assign unused_lead = ^{clk, rst_n, arm, counting};
         assign lead_done   = 1'b1;
      end else begin : g_count
         logic [1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)        cnt_q <= '0;
            else if (arm)      cnt_q <= '0;
            else if (counting) cnt_q <= cnt_q + 2'd1;
         end
         assign lead_done = (cnt_q == 2'(SYNC_DELAY - 2));
      end
   endgenerate
endmodule

// File: rtl/lpc_sync_wait_sel.sv
module lpc_sync_wait_sel
   import lpc_sync_pkg::*;
#(
   parameter bit MEM_LONG_WAIT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm,
   input  logic [1:0] cyc_type,
   output logic [3:0] wait_code,
   output logic       is_dma
);
   logic [3:0] mem_code;
   logic [3:0] pick;

   generate
      if (MEM_LONG_WAIT) begin : g_mem_long
         assign mem_code = NIB_LONG;
      end else begin : g_mem_short
         assign mem_code = NIB_SHORT;
      end
   endgenerate

   always_comb begin
      unique case (cyc_type)
         CT_DMA:  pick = NIB_SHORT;
         CT_MEM:  pick = mem_code;
         default: pick = NIB_LONG;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_code <= NIB_LONG;
         is_dma    <= 1'b0;
      end else if (arm) begin
         wait_code <= pick;
         is_dma    <= (cyc_type == CT_DMA);
      end
   end
endmodule

// File: rtl/lpc_sync_fsm.sv
module lpc_sync_fsm
   import lpc_sync_pkg::*;
#(
   parameter int SYNC_DELAY = 2,
   parameter int BCW        = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cyc_start,
   input  logic           cyc_rd,
   input  logic [BCW-1:0] cyc_nbytes,
   input  logic           fn_ready,
   input  logic           fn_error,
   input  logic           lead_done,
   output logic           arm,
   output sync_st_e       st
);
   sync_st_e       nxt;
   logic [BCW-1:0] left_q;
   logic           err_q;
   logic           rd_q;
   logic           taken;

   assign arm   = (st == ST_IDLE) && cyc_start;
   assign taken = (st == ST_SYNC) && (fn_ready || fn_error);

   always_comb begin
      nxt = st;
      unique case (st)
         ST_IDLE: if (cyc_start) nxt = (SYNC_DELAY == 1) ? ST_SYNC : ST_LEAD;
         ST_LEAD: if (lead_done) nxt = ST_SYNC;
         ST_SYNC: if (taken) nxt = rd_q ? ST_DAT0 : ST_TAR;
         ST_DAT0: nxt = ST_DAT1;
         ST_DAT1: nxt = (!err_q && left_q != '0) ? ST_SYNC : ST_TAR;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         left_q <= '0;
         err_q  <= 1'b0;
         rd_q   <= 1'b0;
      end else begin
         st <= nxt;
         if (arm) begin
            left_q <= cyc_nbytes;
            err_q  <= 1'b0;
            rd_q   <= cyc_rd;
         end else if (taken) begin
            err_q <= fn_error;
         end else if (st == ST_DAT1 && nxt == ST_SYNC) begin
            left_q <= left_q - 1'b1;
         end
      end
   end

   // R2
   first_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(arm, SYNC_DELAY) |-> st == ST_SYNC);
   // R7
   err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DAT1 && err_q) |=> st == ST_TAR);
   // R8
   wr_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && !rd_q) |=> st == ST_TAR);
endmodule

// File: rtl/lpc_sync_gen.sv
module lpc_sync_gen
   import lpc_sync_pkg::*;
#(
   parameter int SYNC_DELAY    = 2,
   parameter int MAX_BYTES     = 4,
   parameter bit MEM_LONG_WAIT = 1'b1,
   localparam int BCW          = $clog2(MAX_BYTES)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cyc_start,
   input  logic [1:0]     cyc_type,
   input  logic           cyc_rd,
   input  logic [BCW-1:0] cyc_nbytes,
   input  logic           fn_ready,
   input  logic           fn_error,
   input  logic           dma_more,
   input  logic [3:0]     rd_nib,
   output logic [3:0]     lad_out,
   output logic           lad_oe,
   output logic           data_phase,
   output logic           data_nib_hi,
   output logic           cyc_done
);
   generate
      if (SYNC_DELAY < 1 || SYNC_DELAY > 3) begin : g_bad_delay
         $error("SYNC_DELAY must lie in 1..3");
      end
      if (MAX_BYTES < 2) begin : g_bad_bytes
         $error("MAX_BYTES must be at least 2");
      end
   endgenerate

   sync_st_e   st;
   logic       arm;
   logic       lead_done;
   logic [3:0] wait_code;
   logic       is_dma;
   logic [3:0] ready_code;

   lpc_sync_fsm #(.SYNC_DELAY(SYNC_DELAY), .BCW(BCW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_rd(cyc_rd),
      .cyc_nbytes(cyc_nbytes), .fn_ready(fn_ready), .fn_error(fn_error),
      .lead_done(lead_done), .arm(arm), .st(st));

   lpc_sync_lead #(.SYNC_DELAY(SYNC_DELAY)) u_lead (
      .clk(clk), .rst_n(rst_n), .arm(arm),
      .counting(st == ST_LEAD), .lead_done(lead_done));

   lpc_sync_wait_sel #(.MEM_LONG_WAIT(MEM_LONG_WAIT)) u_wsel (
      .clk(clk), .rst_n(rst_n), .arm(arm), .cyc_type(cyc_type),
      .wait_code(wait_code), .is_dma(is_dma));

   assign ready_code = (is_dma && dma_more) ? NIB_MORE : NIB_RDY;

   always_comb begin
      lad_out = 4'b0000;
      unique case (st)
         ST_SYNC: begin
            if (fn_error)      lad_out = NIB_ERR;
            else if (fn_ready) lad_out = ready_code;
            else               lad_out = wait_code;
         end
         ST_DAT0, ST_DAT1: lad_out = rd_nib;
         default: lad_out = 4'b0000;
      endcase
   end

   assign lad_oe      = (st == ST_SYNC) || (st == ST_DAT0) || (st == ST_DAT1);
   assign data_phase  = (st == ST_DAT0) || (st == ST_DAT1);
   assign data_nib_hi = (st == ST_DAT1);
   assign cyc_done    = (st == ST_TAR);

   // R3
   wait_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SYNC && !fn_ready && !fn_error &&
       $past(st == ST_SYNC && !fn_ready && !fn_error)) |-> $stable(lad_out));
   // R6
   data_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_phase && !data_nib_hi) |=> (data_phase && data_nib_hi && lad_oe));
   // R9
   oe_tar_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |-> (!lad_oe && !data_phase));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |=> !cyc_done);
endmodule

// File: tb/tb_lpc_sync_gen.sv
module tb_lpc_sync_gen;
   localparam int SYNC_DELAY = 2;
   localparam int MAX_BYTES  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_start = 1'b0;
   logic [1:0] cyc_type = 2'b00;
   logic       cyc_rd = 1'b0;
   logic [1:0] cyc_nbytes = 2'b00;
   logic       fn_ready = 1'b0;
   logic       fn_error = 1'b0;
   logic       dma_more = 1'b0;
   logic [3:0] rd_nib = 4'h0;
   logic [3:0] lad_out;
   logic       lad_oe, data_phase, data_nib_hi, cyc_done;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc_cnt = 0;

   always #2 clk = ~clk;

   lpc_sync_gen #(.SYNC_DELAY(SYNC_DELAY), .MAX_BYTES(MAX_BYTES)) dut (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_type(cyc_type),
      .cyc_rd(cyc_rd), .cyc_nbytes(cyc_nbytes), .fn_ready(fn_ready),
      .fn_error(fn_error), .dma_more(dma_more), .rd_nib(rd_nib),
      .lad_out(lad_out), .lad_oe(lad_oe), .data_phase(data_phase),
      .data_nib_hi(data_nib_hi), .cyc_done(cyc_done));

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 150000) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc_cnt);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic run_cycle(int ty, bit rd, int nb, int waits, int errb, bit both, bit more);
      bit is_dma = (ty == 2);
      logic [3:0] wcode = is_dma ? 4'b0101 : 4'b0110;
      logic [3:0] rcode = (is_dma && more) ? 4'b1001 : 4'b0000;
      int last = rd ? nb : 0;
      bit stop = 0;
      @(negedge clk);
      cyc_start = 1; cyc_type = 2'(ty); cyc_rd = rd; cyc_nbytes = 2'(nb);
      dma_more = more; fn_ready = 0; fn_error = 0;
      @(negedge clk);
      cyc_start = 0; cyc_type = 2'(ty) ^ 2'b10;
      for (int k = 1; k < SYNC_DELAY; k++) begin
         #1 check("R2 lead oe", {7'd0, lad_oe}, 8'd0);
         @(negedge clk);
      end
      for (int b = 0; b <= last && !stop; b++) begin
         bit is_err = (b == errb);
         for (int w = 0; w < waits; w++) begin
            #1 check("R3 wait nibble", {3'd0, lad_oe, lad_out}, {4'd1, wcode});
            @(negedge clk);
         end
         fn_error = is_err; fn_ready = !is_err || both;
         if (is_err) #1 check("R5 error nibble", {3'd0, lad_oe, lad_out}, {4'd1, 4'b1010});
         else        #1 check("R4 ready nibble", {3'd0, lad_oe, lad_out}, {4'd1, rcode});
         @(negedge clk);
         fn_ready = 0; fn_error = 0;
         if (rd) begin
            logic [3:0] lo = 4'((b * 3 + ty + waits) & 15);
            rd_nib = lo;
            #1 check("R6 data low", {1'b0, lad_oe, data_phase, data_nib_hi, lad_out}, {4'b0110, lo});
            @(negedge clk);
            rd_nib = ~lo;
            #1 check("R6 data high", {1'b0, lad_oe, data_phase, data_nib_hi, lad_out}, {4'b0111, ~lo});
            @(negedge clk);
            if (is_err && b < last) stop = 1;
         end
      end
      if (!rd) #1 check("R8 write ends", {6'd0, lad_oe, cyc_done}, 8'd1);
      else if (stop) #1 check("R7 error stops bytes", {6'd0, lad_oe, cyc_done}, 8'd1);
      else #1 check("R9 turnaround", {6'd0, lad_oe, cyc_done}, 8'd1);
      @(negedge clk);
      #1 check("R9 back to idle", {6'd0, lad_oe, cyc_done}, 8'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset outputs", {6'd0, lad_oe, cyc_done}, 8'd0);
      rst_n = 1;
      @(negedge clk);
      #1 check("R1 after reset", {5'd0, lad_oe, cyc_done, data_phase}, 8'd0);
      for (int ty = 0; ty < 3; ty++)
         for (int rd = 0; rd < 2; rd++)
            for (int nb = 0; nb < MAX_BYTES; nb++)
               for (int waits = 0; waits < 3; waits++)
                  for (int errb = -1; errb <= (rd ? nb : 0); errb++)
                     run_cycle(ty, rd[0], nb, waits, errb, waits[0], ((nb + waits) % 2) == 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule